// File: doc/BRIEF.md
# Binary Tick Counter with Match Alarms

This block is a 32-bit binary counter that advances once for each strobe of a slow time base, nominally 32.768 kHz. The strobe arrives as a single-cycle pulse in the system clock domain. Software reaches the block through a flat 32-bit register window. Through that window it gates counting, loads a new count, reads the current count, and programs three compare values. When the count reaches any of the three compare values, a single-cycle interrupt pulse is raised.

Counting runs only when two bits of the control word are both set. When either bit is cleared, the counter freezes. While it is frozen, software writes to the count and to the compare values are dropped. When counting is enabled again, the count carries on from the frozen value.

Top module: `tick_alarm_timer`

## Requirements
- R1: After reset the count, the control word and the three compare values all read as zero, and `irq` is low.
- R2: Counting runs only when control bit 13 and control bit 8 (control word at offset 0x40) are both 1. While counting runs, each `tick_stb` pulse adds one to the count. While it does not run, `tick_stb` has no effect.
- R3: A write to offset 0x64 loads the count while counting runs. The load takes priority over a coincident tick. While counting is stopped, the write is dropped.
- R4: A read at offset 0x68 returns the count. While counting is stopped, the value is frozen at the last count, and re-enabling resumes from that value rather than from zero.
- R5: The compare values sit at offsets 0x6C, 0x70 and 0x74 and read back what was written. A write to any of them while counting is stopped is dropped.
- R6: `irq` is high for exactly one clock when the count has just taken a new value (by a tick or by a load) that equals any of the three compare values while counting runs. The pulse appears in the first cycle in which the new count can be read. Writing a compare value equal to the present count does not raise `irq`.
- R7: The count wraps from 0xFFFFFFFF to 0.
- R8: The control word reads back the full written value. Offsets other than 0x40, 0x64 (write), 0x68, 0x6C, 0x70 and 0x74 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_stb | input | 1 | One-cycle strobe of the 32.768 kHz time base |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| irq | output | 1 | One-cycle alarm pulse, OR of the three compare units |

## Verification
The bench sets only one of the two enable bits and checks that ticks still do nothing. A design that gated counting on a single bit would count there. It freezes the counter, issues ticks, loads and compare writes, and then resumes. A design that reset the count on enable, or accepted writes while stopped, would read back the wrong value. It loads 0xFFFFFFFF with a compare value of zero to confirm the wrap and the alarm on the wrapped value. It then checks that the following cycle has `irq` low, so a level-style alarm that stays high while the count sits on the matching value would be caught. Finally, it rewrites a compare value to the present count, where a comparator that fires on any equality would pulse wrongly.

// File: rtl/tick_alarm_pkg.sv
// Package: shared widths, register offsets and control bit positions
// for the tick alarm timer. Assumes a byte-addressed 32-bit register window.
package tick_alarm_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int N_MATCH = 3;

    // Register offsets (software-visible, kept fixed)
    localparam logic [ADDR_W-1:0] OFS_CTRL       = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_LOAD       = 8'h64;
    localparam logic [ADDR_W-1:0] OFS_COUNT      = 8'h68;
    localparam logic [ADDR_W-1:0] OFS_MATCH_BASE = 8'h6C;
    localparam int                MATCH_STRIDE   = 4;

    // Control bits that must both be set for counting
    localparam int CTRL_RUN_BIT  = 13;
    localparam int CTRL_GATE_BIT = 8;
endpackage

// File: rtl/tat_regif.sv
// Register interface: decodes bus accesses, holds the control word,
// produces write strobes for the counter and compare units and muxes
// read data. Assumes single-cycle accesses, 32-bit wide only.
module tat_regif
    import tick_alarm_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_sel,
    input  logic                            bus_we,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [DATA_W-1:0]               bus_rdata,
    input  logic [DATA_W-1:0]               count,
    input  logic [N_MATCH-1:0][DATA_W-1:0]  match_val,
    output logic                            running,
    output logic                            load_we,
    output logic [N_MATCH-1:0]              match_we
);
    logic [DATA_W-1:0] ctrl_q;
    logic              wr_acc;
    logic              rd_acc;

    assign wr_acc  = bus_sel && bus_we;
    assign rd_acc  = bus_sel && !bus_we;
    assign running = ctrl_q[CTRL_RUN_BIT] && ctrl_q[CTRL_GATE_BIT];
    assign load_we = wr_acc && running && (bus_addr == OFS_LOAD);

    // Control word register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_acc && bus_addr == OFS_CTRL)
            ctrl_q <= bus_wdata;
    end

    // One compare-write strobe per unit, gated by the run state
    for (genvar i = 0; i < N_MATCH; i++) begin : g_mwe
        localparam logic [ADDR_W-1:0] OFS_I = ADDR_W'(OFS_MATCH_BASE + MATCH_STRIDE * i);
        assign match_we[i] = wr_acc && running && (bus_addr == OFS_I);
    end

    // Read data multiplexer; unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            if (bus_addr == OFS_CTRL)  bus_rdata = ctrl_q;
            if (bus_addr == OFS_COUNT) bus_rdata = count;
            for (int i = 0; i < N_MATCH; i++) begin
                if (bus_addr == ADDR_W'(OFS_MATCH_BASE + MATCH_STRIDE * i))
                    bus_rdata = match_val[i];
            end
        end
    end
endmodule

// File: rtl/tat_counter.sv
// Tick counter: advances on each time-base strobe while running, takes
// a load with priority, and flags the cycle after any change so that
// compare units fire once per new value. Wraps modulo 2^DATA_W.
module tat_counter
    import tick_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              tick_stb,
    input  logic              load_we,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] count,
    output logic              fresh
);
    // Count register with load priority over increment
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load_we)
            count <= load_val;
        else if (running && tick_stb)
            count <= count + 1'b1;
    end

    // Marks the first cycle in which a newly taken value is visible
    always_ff @(posedge clk) begin
        if (!rst_n)
            fresh <= 1'b0;
        else
            fresh <= load_we || (running && tick_stb);
    end
endmodule

// File: rtl/tat_match_unit.sv
// Compare unit: stores one compare value and reports a hit when the
// counter has just taken a value equal to it while counting runs.
module tat_match_unit
    import tick_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [DATA_W-1:0] count,
    input  logic              fresh,
    input  logic              running,
    output logic [DATA_W-1:0] match_val,
    output logic              hit
);
    // Compare value storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_val <= '0;
        else if (wr_en)
            match_val <= wr_val;
    end

    // Hit only on a freshly taken count value
    assign hit = fresh && running && (count == match_val);
endmodule

// File: rtl/tick_alarm_timer.sv
// Top: tick counter with three compare alarms behind a 32-bit register
// window. The alarm output is the OR of all compare unit hits.
module tick_alarm_timer
    import tick_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_stb,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    logic                           running;
    logic                           load_we;
    logic [N_MATCH-1:0]             match_we;
    logic [DATA_W-1:0]              count_q;
    logic                           fresh;
    logic [N_MATCH-1:0][DATA_W-1:0] match_val;
    logic [N_MATCH-1:0]             hit;

    tat_regif u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count_q),
        .match_val (match_val),
        .running   (running),
        .load_we   (load_we),
        .match_we  (match_we)
    );

    tat_counter u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .running  (running),
        .tick_stb (tick_stb),
        .load_we  (load_we),
        .load_val (bus_wdata),
        .count    (count_q),
        .fresh    (fresh)
    );

    for (genvar i = 0; i < N_MATCH; i++) begin : g_match
        tat_match_unit u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (match_we[i]),
            .wr_val    (bus_wdata),
            .count     (count_q),
            .fresh     (fresh),
            .running   (running),
            .match_val (match_val[i]),
            .hit       (hit[i])
        );
    end

    assign irq = |hit;
endmodule

// File: rtl/tick_alarm_timer_sva.sv
// Checker for the tick alarm timer, bound to the top; watches ports and
// the internal count and run state.
module tick_alarm_timer_sva
    import tick_alarm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_stb,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [7:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       count_q,
    input logic              running,
    input logic              irq
);
    logic load_acc;
    assign load_acc = bus_sel && bus_we && (bus_addr == OFS_LOAD);

    // R6: an alarm never appears while counting is stopped
    p_irq_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> running);

    // R4: a stopped counter keeps its value
    p_hold_when_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!running) |-> $stable(count_q));

    // R2, R7: one step per tick, modulo the width
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick_stb && !load_acc) |=> (count_q == $past(count_q) + 32'd1));

    // R3: a load while running takes the written value
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && load_acc) |=> (count_q == $past(bus_wdata)));

    // R6: no alarm without a fresh count value
    p_irq_needs_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !$stable(count_q) || $past(load_acc));
endmodule

bind tick_alarm_timer tick_alarm_timer_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_stb  (tick_stb),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .count_q   (count_q),
    .running   (running),
    .irq       (irq)
);

// File: tb/tick_alarm_timer_test.sv
module tick_alarm_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_stb = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic irq_seen;
    logic [31:0] rd_val;

    always #5 clk = ~clk;

    tick_alarm_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_stb(tick_stb),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;
    localparam logic [31:0] RUN = 32'h0000_2100;
    // {op, addr, data, expected}
    localparam logic [73:0] VEC [16] = '{
        {OP_WR, 8'h40, RUN,          32'h0},
        {OP_RD, 8'h40, 32'h0,        RUN},
        {OP_WR, 8'h64, 32'h5,        32'h0},
        {OP_RD, 8'h68, 32'h0,        32'h5},
        {OP_TK, 8'h00, 32'h0,        32'h0},
        {OP_RD, 8'h68, 32'h0,        32'h6},
        {OP_WR, 8'h6C, 32'h8,        32'h0},
        {OP_WR, 8'h70, 32'h20,       32'h0},
        {OP_RD, 8'h6C, 32'h0,        32'h8},
        {OP_RD, 8'h70, 32'h0,        32'h20},
        {OP_TK, 8'h00, 32'h0,        32'h0},
        {OP_TK, 8'h00, 32'h0,        32'h1},
        {OP_RD, 8'h68, 32'h0,        32'h8},
        {OP_WR, 8'h64, 32'h1F,       32'h0},
        {OP_TK, 8'h00, 32'h0,        32'h1},
        {OP_RD, 8'h74, 32'h0,        32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Tick, then sample irq in the cycle the new count is visible
    task automatic tick(output logic seen);
        @(negedge clk);
        tick_stb = 1'b1;
        @(negedge clk);
        tick_stb = 1'b0;
        seen = irq;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        bus_rd(8'h68, rd_val); chk("R1 count", rd_val, 32'h0);
        bus_rd(8'h40, rd_val); chk("R1 ctrl", rd_val, 32'h0);
        bus_rd(8'h70, rd_val); chk("R1 match1", rd_val, 32'h0);

        // R2: one enable bit alone does not count
        bus_wr(8'h40, 32'h0000_2000);
        tick(irq_seen);
        bus_rd(8'h68, rd_val); chk("R2 bit13 only", rd_val, 32'h0);
        bus_wr(8'h40, 32'h0000_0100);
        tick(irq_seen);
        bus_rd(8'h68, rd_val); chk("R2 bit8 only", rd_val, 32'h0);
        // R3: load dropped when stopped
        bus_wr(8'h64, 32'h1234);
        bus_rd(8'h68, rd_val); chk("R3 load stopped", rd_val, 32'h0);

        // Vector walk (R2, R3, R4, R5, R6, R8)
        foreach (VEC[i]) begin
            case (VEC[i][73:72])
                OP_WR: bus_wr(VEC[i][71:64], VEC[i][63:32]);
                OP_RD: begin
                    bus_rd(VEC[i][71:64], rd_val);
                    chk($sformatf("R4/R5/R8 vec%0d", i), rd_val, VEC[i][31:0]);
                end
                default: begin
                    tick(irq_seen);
                    chk($sformatf("R6 vec%0d", i), {31'b0, irq_seen}, VEC[i][31:0]);
                end
            endcase
        end

        // R6: the pulse lasts one cycle
        bus_wr(8'h64, 32'h100);
        tick(irq_seen); // count 0x101
        bus_wr(8'h74, 32'h102);
        tick(irq_seen);
        chk("R6 hit m2", {31'b0, irq_seen}, 32'h1);
        @(negedge clk); chk("R6 one cycle", {31'b0, irq}, 32'h0);
        // R6: writing a compare equal to the present count does not fire
        bus_wr(8'h6C, 32'h102);
        chk("R6 no fire on compare write", {31'b0, irq}, 32'h0);

        // R4/R5: freeze, drop writes, resume
        bus_wr(8'h40, 32'h0000_2000);
        tick(irq_seen);
        chk("R6 no irq stopped", {31'b0, irq_seen}, 32'h0);
        tick(irq_seen);
        bus_wr(8'h70, 32'hABCD);
        bus_wr(8'h64, 32'h7);
        bus_rd(8'h70, rd_val); chk("R5 match write stopped", rd_val, 32'h20);
        bus_rd(8'h68, rd_val); chk("R4 frozen", rd_val, 32'h102);
        bus_wr(8'h40, RUN);
        tick(irq_seen);
        bus_rd(8'h68, rd_val); chk("R4 resume", rd_val, 32'h103);

        // R7: wrap with a compare of zero
        bus_wr(8'h74, 32'h0);
        bus_wr(8'h64, 32'hFFFF_FFFF);
        tick(irq_seen);
        chk("R7 irq on wrap", {31'b0, irq_seen}, 32'h1);
        bus_rd(8'h68, rd_val); chk("R7 wrap", rd_val, 32'h0);

        // R8: unmapped offsets
        bus_rd(8'h80, rd_val); chk("R8 unmapped read", rd_val, 32'h0);
        bus_wr(8'h00, 32'hFFFF_FFFF);
        bus_wr(8'h44, 32'h0);
        bus_rd(8'h40, rd_val); chk("R8 ctrl untouched", rd_val, RUN);
        bus_rd(8'h68, rd_val); chk("R8 count untouched", rd_val, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule